// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit sits next to a small 8-bit processor core and handles everything about interrupts that happens between two instructions. It owns three architectural registers: the interrupt enable mask, the interrupt status, and the stack pointer. A free-running tick counter raises status bit 0 at a fixed interval. Software can also raise any status bit through a software-interrupt request. When the core reports an instruction boundary and some status bit is also enabled in the mask, the unit takes the lowest-numbered such request. It pushes the core's program counter, flags and seven general registers onto a stack in memory, reads the handler address from a vector table at the top of memory, and clears the whole mask so that no nested interrupt is accepted.

When the core reports a boundary together with a return request, the unit runs the mirror sequence. It pops the seven registers, the flags and the program counter, hands them back to the core, and sets every mask bit. The memory side is a byte-wide request stream with valid/ready flow control. While the unit holds the core (`hold_o` high), the core stays at its boundary and waits for the one-cycle completion pulse.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the stack pointer reads 0xF4, the mask and status read 0x00, and `hold_o`, `mem_valid` and `done_o` are low.
- R2: A register write with index 5 loads the mask, index 6 loads the status and index 7 loads the stack pointer. Indices 0 to 4 change none of the three. Any write presented while `hold_o` is high is ignored.
- R3: The tick counter sets status bit 0 on the TICK_PERIOD-th rising edge after reset release, and then again every TICK_PERIOD edges, independently of register writes.
- R4: A software request with value v below 8 sets status bit v. A value of 8 or above changes nothing, and so does a request presented while `hold_o` is high.
- R5: When `at_boundary` is high, `iret_req` is low, `hold_o` is low and status AND mask is non-zero, the unit takes the lowest-numbered pending bit n. On that same edge it clears status bit n and raises `hold_o`.
- R6: Entry performs nine writes, each to the stack pointer minus one, with the stack pointer decremented per write. The values go out in the order PC, flags, R0 to R6, so the stack pointer ends nine below its entry value.
- R7: After the pushes, entry reads address 0xF8+n. It then pulses `done_o` for one cycle with `done_ret_o` low and `pc_out` equal to the byte read, and the mask already reads 0x00.
- R8: A boundary with `iret_req` high starts a return even if interrupts are pending. It performs nine reads at the stack pointer, post-incrementing it, and fills R6 down to R0, then flags, then PC. It then pulses `done_o` with `done_ret_o` high, with the popped values on `regs_out` (R0 in bits 7:0), `fl_out` and `pc_out`, and with the mask reading 0xFF.
- R9: A memory request, once valid, keeps its address, direction and write data until `mem_ready` is sampled high. Read data is taken in the accepting cycle. No request is made while `hold_o` is low. An entry makes exactly ten transfers and a return makes nine.
- R10: At a boundary with nothing pending and no return request, the unit stays idle: `hold_o` and `mem_valid` remain low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Core is between instructions and may be held |
| iret_req | input | 1 | Return-from-interrupt request, sampled with at_boundary |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index (5 mask, 6 status, 7 stack pointer) |
| reg_wdata | input | 8 | Register write data |
| swi_valid | input | 1 | Software interrupt request strobe |
| swi_val | input | 8 | Interrupt number to raise |
| core_pc | input | 8 | Core program counter to save |
| core_fl | input | 8 | Core flags to save |
| core_regs | input | 56 | Core registers R0..R6, R0 in bits 7:0 |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 8 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the accepting cycle |
| hold_o | output | 1 | Core must stay at its boundary |
| done_o | output | 1 | One-cycle sequence completion pulse |
| done_ret_o | output | 1 | Completed sequence was a return |
| pc_out | output | 8 | Handler address or restored PC |
| fl_out | output | 8 | Restored flags |
| regs_out | output | 56 | Restored R0..R6 |
| im_o | output | 8 | Interrupt mask |
| is_o | output | 8 | Interrupt status |
| sp_o | output | 8 | Stack pointer |

## Verification
A wrong frame index or stack pointer step shows up as soon as the sequence finishes. The stack bytes land at the wrong addresses, or a return hands back registers in the wrong order, so both are compared at the next `done_o`. A bad priority choice or a missed status clear shows on `is_o` one cycle after the boundary. A wrong vector is visible on `pc_out` at the completion pulse. Flow-control faults are provoked by random `mem_ready` stalls. Against those, a dropped or repeated transfer changes the transfer count and the memory image within the same sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_POP,
    ST_DONE
  } seq_state_e;

  localparam int unsigned IDX_MASK = 5;
  localparam int unsigned IDX_STAT = 6;
  localparam int unsigned IDX_SP   = 7;
  localparam int unsigned IDX_W    = 3;
endpackage

// File: rtl/irq_tick.sv
module irq_tick #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] lower_set;
  logic [N-1:0] grant;

  assign lower_set[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign lower_set[i] = lower_set[i-1] | req[i-1];
  end
  assign grant = req & ~lower_set;
  assign any_o = |req;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_csr.sv
module irq_csr import irq_pkg::*; #(
  parameter int unsigned DW      = 8,
  parameter int unsigned IW      = 3,
  parameter logic [DW-1:0] SP_INIT = 8'hF4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             swi_en,
  input  logic [DW-1:0]    swi_val,
  input  logic             tick,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  input  logic             im_clear,
  input  logic             im_fill,
  input  logic             sp_dec,
  input  logic             sp_inc,
  output logic [DW-1:0]    im_q,
  output logic [DW-1:0]    is_q,
  output logic [DW-1:0]    sp_q
);
  logic [DW-1:0] im_n, is_n, sp_n;
  logic          swi_in_range;

  assign swi_in_range = (swi_val < DW'(DW));

  always_comb begin
    im_n = im_q;
    if (wr_en && wr_idx == IDX_W'(IDX_MASK)) im_n = wr_data;
    if (im_clear) im_n = '0;
    if (im_fill)  im_n = '1;

    // write first, then the dispatch clear, then new events win
    is_n = is_q;
    if (wr_en && wr_idx == IDX_W'(IDX_STAT)) is_n = wr_data;
    if (clr_en) is_n[clr_idx] = 1'b0;
    if (tick)   is_n[0] = 1'b1;
    if (swi_en && swi_in_range) is_n[swi_val[IW-1:0]] = 1'b1;

    sp_n = sp_q;
    if (wr_en && wr_idx == IDX_W'(IDX_SP)) sp_n = wr_data;
    if (sp_dec) sp_n = sp_q - 1'b1;
    if (sp_inc) sp_n = sp_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      im_q <= '0;
      is_q <= '0;
      sp_q <= SP_INIT;
    end else begin
      im_q <= im_n;
      is_q <= is_n;
      sp_q <= sp_n;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq import irq_pkg::*; #(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   NSAVE    = 7,
  parameter int unsigned   IW       = 3,
  parameter logic [DW-1:0] VEC_BASE = 8'hF8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                at_boundary,
  input  logic                iret_req,
  input  logic                pend_any,
  input  logic [IW-1:0]       pend_idx,
  input  logic [DW-1:0]       core_pc,
  input  logic [DW-1:0]       core_fl,
  input  logic [NSAVE*DW-1:0] core_regs,
  input  logic [DW-1:0]       sp,
  input  logic                mem_ready,
  input  logic [DW-1:0]       mem_rdata,
  output logic                mem_valid,
  output logic                mem_we,
  output logic [DW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                sp_dec,
  output logic                sp_inc,
  output logic                clr_en,
  output logic [IW-1:0]       clr_idx,
  output logic                im_clear,
  output logic                im_fill,
  output logic                busy,
  output logic                done,
  output logic                done_ret,
  output logic [DW-1:0]       pc_out,
  output logic [DW-1:0]       fl_out,
  output logic [NSAVE*DW-1:0] regs_out
);
  localparam int unsigned NF = NSAVE + 2;
  localparam int unsigned KW = $clog2(NF + 1);
  localparam logic [KW-1:0] K_LAST = KW'(NF - 1);

  seq_state_e    st_q;
  logic [KW-1:0] k_q;
  logic          ret_q;
  logic [IW-1:0] vec_q;
  logic [DW-1:0] frame_q [NF];
  logic          xfer, start_ent, start_ret;

  assign xfer      = mem_valid & mem_ready;
  assign start_ret = (st_q == ST_IDLE) && at_boundary && iret_req;
  assign start_ent = (st_q == ST_IDLE) && at_boundary && !iret_req && pend_any;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_PUSH: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp - 1'b1;
        mem_wdata = frame_q[k_q];
      end
      ST_VEC: begin
        mem_valid = 1'b1;
        mem_addr  = VEC_BASE + DW'(vec_q);
      end
      ST_POP: begin
        mem_valid = 1'b1;
        mem_addr  = sp;
      end
      default: ;
    endcase
  end

  assign sp_dec   = (st_q == ST_PUSH) && xfer;
  assign sp_inc   = (st_q == ST_POP) && xfer;
  assign im_clear = (st_q == ST_VEC) && xfer;
  assign im_fill  = (st_q == ST_POP) && xfer && (k_q == K_LAST);
  assign clr_en   = start_ent;
  assign clr_idx  = pend_idx;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign done_ret = done && ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      k_q   <= '0;
      ret_q <= 1'b0;
      vec_q <= '0;
      for (int i = 0; i < NF; i++) frame_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          k_q <= '0;
          if (start_ret) begin
            ret_q <= 1'b1;
            st_q  <= ST_POP;
          end else if (start_ent) begin
            ret_q      <= 1'b0;
            vec_q      <= pend_idx;
            frame_q[0] <= core_pc;
            frame_q[1] <= core_fl;
            for (int i = 0; i < NSAVE; i++) frame_q[i+2] <= core_regs[i*DW +: DW];
            st_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (xfer) begin
            k_q <= k_q + 1'b1;
            if (k_q == K_LAST) st_q <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (xfer) begin
            frame_q[0] <= mem_rdata;
            st_q       <= ST_DONE;
          end
        end
        ST_POP: begin
          if (xfer) begin
            frame_q[K_LAST - k_q] <= mem_rdata;
            k_q <= k_q + 1'b1;
            if (k_q == K_LAST) st_q <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_out = frame_q[0];
  assign fl_out = frame_q[1];
  for (genvar i = 0; i < NSAVE; i++) begin : g_regs
    assign regs_out[i*DW +: DW] = frame_q[i+2];
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch import irq_pkg::*; #(
  parameter int unsigned   DW          = 8,
  parameter int unsigned   NSAVE       = 7,
  parameter int unsigned   TICK_PERIOD = 1000,
  parameter logic [DW-1:0] SP_INIT     = 8'hF4,
  parameter logic [DW-1:0] VEC_BASE    = 8'hF8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                at_boundary,
  input  logic                iret_req,
  input  logic                reg_we,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [DW-1:0]       reg_wdata,
  input  logic                swi_valid,
  input  logic [DW-1:0]       swi_val,
  input  logic [DW-1:0]       core_pc,
  input  logic [DW-1:0]       core_fl,
  input  logic [NSAVE*DW-1:0] core_regs,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [DW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                hold_o,
  output logic                done_o,
  output logic                done_ret_o,
  output logic [DW-1:0]       pc_out,
  output logic [DW-1:0]       fl_out,
  output logic [NSAVE*DW-1:0] regs_out,
  output logic [DW-1:0]       im_o,
  output logic [DW-1:0]       is_o,
  output logic [DW-1:0]       sp_o
);
  localparam int unsigned IW = $clog2(DW);

  logic          tick, pend_any, busy;
  logic [IW-1:0] pend_idx, clr_idx;
  logic          clr_en, im_clear, im_fill, sp_dec, sp_inc;

  irq_tick #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  irq_csr #(.DW(DW), .IW(IW), .SP_INIT(SP_INIT)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we && !busy), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .swi_en(swi_valid && !busy), .swi_val(swi_val),
    .tick(tick), .clr_en(clr_en), .clr_idx(clr_idx),
    .im_clear(im_clear), .im_fill(im_fill),
    .sp_dec(sp_dec), .sp_inc(sp_inc),
    .im_q(im_o), .is_q(is_o), .sp_q(sp_o)
  );

  irq_pick #(.N(DW), .IW(IW)) u_pick (
    .req(is_o & im_o), .any_o(pend_any), .idx_o(pend_idx)
  );

  irq_seq #(.DW(DW), .NSAVE(NSAVE), .IW(IW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .at_boundary(at_boundary), .iret_req(iret_req),
    .pend_any(pend_any), .pend_idx(pend_idx),
    .core_pc(core_pc), .core_fl(core_fl), .core_regs(core_regs),
    .sp(sp_o), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .clr_en(clr_en), .clr_idx(clr_idx),
    .im_clear(im_clear), .im_fill(im_fill),
    .busy(busy), .done(done_o), .done_ret(done_ret_o),
    .pc_out(pc_out), .fl_out(fl_out), .regs_out(regs_out)
  );

  assign hold_o = busy;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] SP_INIT = 8'hF4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          hold_o,
  input logic          done_o,
  input logic          done_ret_o,
  input logic [DW-1:0] im_o,
  input logic [DW-1:0] is_o,
  input logic [DW-1:0] sp_o
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (sp_o == SP_INIT && im_o == '0 && !hold_o)); // R1
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !hold_o |-> !mem_valid); // R9
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_ready && mem_we) |=> sp_o == $past(mem_addr)); // R6
  AST_SP_STALL: assert property (@(posedge clk) disable iff (!rst_n) (hold_o && !(mem_valid && mem_ready)) |=> $stable(sp_o)); // R2
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !done_ret_o) |-> im_o == '0); // R7
  AST_RET_MASK: assert property (@(posedge clk) disable iff (!rst_n) (done_o && done_ret_o) |-> im_o == '1); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> (!done_o && !hold_o)); // R7
endmodule

bind irq_dispatch irq_dispatch_chk #(.DW(DW), .SP_INIT(SP_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .hold_o(hold_o), .done_o(done_o), .done_ret_o(done_ret_o),
  .im_o(im_o), .is_o(is_o), .sp_o(sp_o)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int P = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic at_boundary = 0, iret_req = 0, reg_we = 0, swi_valid = 0, mem_ready = 0;
  logic [2:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0, swi_val = '0, core_pc = '0, core_fl = '0;
  logic [55:0] core_regs = '0;
  logic        mem_valid, mem_we, hold_o, done_o, done_ret_o;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata, pc_out, fl_out, im_o, is_o, sp_o;
  logic [55:0] regs_out;
  logic [7:0]  mem [256];
  int n_chk = 0, n_fail = 0, hs_cnt = 0;
  bit ready_rand = 0;

  always #10 clk = ~clk;

  irq_dispatch #(.TICK_PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .iret_req(iret_req),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .swi_valid(swi_valid), .swi_val(swi_val),
    .core_pc(core_pc), .core_fl(core_fl), .core_regs(core_regs),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .hold_o(hold_o), .done_o(done_o), .done_ret_o(done_ret_o),
    .pc_out(pc_out), .fl_out(fl_out), .regs_out(regs_out),
    .im_o(im_o), .is_o(is_o), .sp_o(sp_o)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      hs_cnt = hs_cnt + 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  always @(negedge clk) mem_ready <= ready_rand ? (($urandom % 4) != 0) : 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    reg_we = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    bit got;
    void'($urandom(32'd271));
    for (int a = 0; a < 256; a++) mem[a] = 8'(a);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 timer phase, R1 reset state
    for (int e = 1; e <= P; e++) begin
      @(negedge clk);
      if (e == 1) begin
        chk("R1 sp", sp_o, 8'hF4); chk("R1 im", im_o, 0); chk("R1 is", is_o, 0);
        chk("R1 hold/valid/done", {hold_o, mem_valid, done_o}, 0);
      end
      if (e == P-1) chk("R3 before tick", is_o[0], 0);
      if (e == P)   chk("R3 first tick", is_o[0], 1);
    end
    reg_we = 1; reg_idx = 3'd6; reg_wdata = 8'h00;
    for (int e = P+1; e <= 2*P; e++) begin
      @(negedge clk);
      reg_we = 0;
      if (e == P+1)   chk("R3 cleared by write", is_o[0], 0);
      if (e == 2*P-1) chk("R3 before second tick", is_o[0], 0);
      if (e == 2*P)   chk("R3 second tick", is_o[0], 1);
    end
    // R2 directed
    wr(3'd5, 8'hA6); chk("R2 mask write", im_o, 8'hA6);
    wr(3'd7, 8'h90); chk("R2 sp write", sp_o, 8'h90);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h55);
    chk("R2 idx2 ignored", {im_o, is_o[7:1], sp_o}, {8'hA6, 7'h00, 8'h90});
    // R4 software requests
    swi_valid = 1; swi_val = 8'd9; @(negedge clk); swi_valid = 0;
    chk("R4 out of range", is_o[7:1], 0);
    swi_valid = 1; swi_val = 8'd5; @(negedge clk); swi_valid = 0;
    chk("R4 sets bit5", is_o[7:1], 7'h10);
    // R10 nothing pending
    wr(3'd5, 8'h00);
    wr(3'd6, 8'hFE);
    at_boundary = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 stays idle", {hold_o, mem_valid}, 0);
    end
    at_boundary = 0;
    ready_rand = 1;
    // random entry / return pairs
    for (int it = 0; it < 24; it++) begin
      logic [7:0] sp0, imv, isv, vec [8], fr [9], nf [9];
      int n;
      sp0 = 8'h30 + 8'($urandom % 128);
      imv = 8'($urandom) & 8'hFE;
      if (imv == 0) imv = 8'h80;
      isv = (8'($urandom) | (8'h1 << ($urandom % 8))) & 8'hFE;
      if ((isv & imv) == 0) isv = isv | (imv & ~(imv - 1));
      if (it == 0) begin imv = 8'hFE; isv = 8'h0A; end
      for (int i = 0; i < 8; i++) begin vec[i] = 8'($urandom); mem[8'hF8 + i] = vec[i]; end
      for (int i = 0; i < 9; i++) fr[i] = 8'($urandom);
      core_pc = fr[0]; core_fl = fr[1];
      for (int i = 0; i < 7; i++) core_regs[i*8 +: 8] = fr[i+2];
      wr(3'd7, sp0); wr(3'd5, imv); wr(3'd6, isv);
      n = lowest(isv & imv);
      hs_cnt = 0;
      at_boundary = 1;
      @(negedge clk);
      at_boundary = 0;
      chk("R5 hold raised", hold_o, 1);
      chk("R5 serviced bit cleared", is_o[7:1], 7'((isv & ~(8'h1 << n)) >> 1));
      reg_we = 1; reg_idx = 3'd7; reg_wdata = 8'h11;
      @(negedge clk);
      reg_we = 0;
      wait_done(got);
      chk("R7 done seen", got, 1);
      chk("R7 entry kind", done_ret_o, 0);
      chk("R7 vector", pc_out, vec[n]);
      chk("R7 mask cleared", im_o, 0);
      chk("R6 sp after entry (R2 write during hold ignored)", sp_o, sp0 - 8'd9);
      chk("R9 entry transfers", hs_cnt, 10);
      for (int i = 0; i < 9; i++) chk("R6 stacked value", mem[sp0 - 8'(i + 1)], fr[i]);
      @(negedge clk);
      // new frame for the return: pc, fl, r0..r6
      for (int i = 0; i < 9; i++) begin nf[i] = 8'($urandom); mem[sp0 - 8'(i + 1)] = nf[i]; end
      if (it == 1) begin wr(3'd5, 8'hFF); wr(3'd6, 8'h0C); end
      hs_cnt = 0;
      at_boundary = 1; iret_req = 1;
      @(negedge clk);
      at_boundary = 0; iret_req = 0;
      wait_done(got);
      chk("R8 done seen", got, 1);
      chk("R8 return kind", done_ret_o, 1);
      chk("R8 pc", pc_out, nf[0]);
      chk("R8 flags", fl_out, nf[1]);
      for (int i = 0; i < 7; i++) chk("R8 reg", regs_out[i*8 +: 8], nf[i+2]);
      chk("R8 mask all ones", im_o, 8'hFF);
      chk("R8 sp restored", sp_o, sp0);
      chk("R9 return transfers", hs_cnt, 9);
      if (it == 1) chk("R8 return beats pending", is_o[7:1], 7'h06);
      @(negedge clk);
    end
    finish_run();
  end
endmodule